// File: doc/BRIEF.md
# Extended Accumulator Register with Saturation and Convergent Rounding

This block is the result register that sits after the adder of a multiply-accumulate datapath. It holds a 40-bit value in three parts: an 8-bit guard part on top and two 16-bit words below it. Each accumulate cycle writes a new 40-bit sum into it. That sum may first be rounded at the boundary between bit 15 and bit 16. Instead of the accumulator, the rounded sum can go to a separate 16-bit feedback register, which receives the upper word of the 32-bit product field.

Every accumulate refreshes an overflow flag. The flag goes high when the guard bits and the top bit of the upper word no longer form a plain sign extension. A saturate command can be issued at the end of a run of accumulations to clamp the register to full-scale positive or negative. A 16-bit data bus loads the three parts one at a time. Loading the upper word also sign-fills the guard part, so that a 16-bit value becomes a correctly signed 40-bit value in one write. The guard part is also presented sign-extended to 16 bits for readout.

Rounding is unbiased. A constant of one half LSB is added at bit 15 and the carry ripples upward. When the discarded half is exactly one half, the new LSB of the upper word is cleared, so ties settle on an even value.

Top module: `acc_ext_reg`

## Requirements
- R1: While reset is low and on the first cycle after it, the three parts, the overflow flag and the feedback register read zero.
- R2: A load of the low word writes bus bits 15..0 into bits 15..0 only. The guard part and the upper word keep their values, and so does the overflow flag.
- R3: A load of the upper word writes the bus into bits 31..16 and copies bus bit 15 into all 8 guard bits. A guard load in the same cycle writes bus bits 7..0 into the guard part instead of the fill.
- R4: Output mr_hi_ext always equals the guard part sign-extended to 16 bits: bits 15..8 repeat guard bit 7.
- R5: Each accumulate cycle sets the overflow flag to 1 exactly when bits 39..31 of the written result are neither all 0 nor all 1. Any cycle without an accumulate leaves the flag unchanged. With the accumulator as target, the whole 40-bit result is written.
- R6: A saturate command while the overflow flag is 0 leaves all 40 bits unchanged.
- R7: A saturate command while the overflow flag is 1 writes 0x00_7FFF_FFFF if guard bit 7 is 0, and 0xFF_8000_0000 if it is 1. Saturation does not change the flag.
- R8: With rounding requested, the result is the sum plus 0x8000 with full carry propagation into bits 39..16. Bits 15..0 of the result are those of the addition.
- R9: With rounding requested and sum bits 15..0 equal to 0x8000 exactly, bit 16 of the result is forced to 0.
- R10: With the feedback register as target, it receives bits 31..16 of the (rounded if requested) result and the 40-bit accumulator stays unchanged.
- R11: Priority within a cycle is accumulate, then saturate, then bus loads. Lower-priority requests in the same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Accumulate: write the adder sum this cycle |
| acc_sum | input | 40 | 40-bit sum from the adder |
| acc_round | input | 1 | Round the sum at bit 15/16 before writing |
| acc_to_fb | input | 1 | 1: target the 16-bit feedback register; 0: target the accumulator |
| sat_cmd | input | 1 | Saturate command |
| bus_data | input | 16 | Data bus for part loads |
| ld_lo | input | 1 | Load strobe, bits 15..0 |
| ld_mid | input | 1 | Load strobe, bits 31..16 (with guard sign fill) |
| ld_hi | input | 1 | Load strobe, guard bits 39..32 from bus bits 7..0 |
| mr_hi | output | 8 | Guard part, bits 39..32 |
| mr_mid | output | 16 | Upper word, bits 31..16 |
| mr_lo | output | 16 | Low word, bits 15..0 |
| mr_hi_ext | output | 16 | Guard part sign-extended to 16 bits |
| ovf_flag | output | 1 | Accumulator overflow flag |
| fb_word | output | 16 | Feedback register |

## Verification
The bench builds the block with its default widths: an 8-bit guard part and 16-bit words. At these widths the 40-bit patterns from the requirements can be used literally. The two saturation constants, the nine-bit overflow window and the 0x8000 tie pattern all appear at their real bit positions. This reaches the cases that need a carry to ripple from bit 15 through the upper word into the guard part, and the tie cases with both an odd and an even upper word. It also reaches a single cycle that asserts all the competing commands together.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // Which source updates the 40-bit accumulator in a cycle.
  typedef enum logic [1:0] {
    WR_HOLD = 2'd0,
    WR_ACC  = 2'd1,
    WR_SAT  = 2'd2,
    WR_BUS  = 2'd3
  } acc_wr_e;

  // Fixed priority: accumulate, then saturate, then bus loads.
  function automatic acc_wr_e pick_write(input logic acc_valid,
                                         input logic to_fb,
                                         input logic sat_cmd,
                                         input logic any_load);
    acc_wr_e sel;
    if (acc_valid)
      sel = to_fb ? WR_HOLD : WR_ACC;
    else if (sat_cmd)
      sel = WR_SAT;
    else if (any_load)
      sel = WR_BUS;
    else
      sel = WR_HOLD;
    return sel;
  endfunction

  // The overflow flag moves only when an accumulate happens.
  function automatic logic flag_update(input logic acc_valid);
    return acc_valid;
  endfunction

endpackage

// File: rtl/acc_round_unit.sv
module acc_round_unit #(
  parameter int ACC_W   = 40,
  parameter int RND_POS = 16
) (
  input  logic [ACC_W-1:0] sum_in,
  input  logic             rnd_en,
  output logic [ACC_W-1:0] res_out,
  output logic             tie_hit
);

  localparam logic [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (RND_POS - 1);
  localparam logic [RND_POS-1:0] TIE_PAT = RND_POS'(1) << (RND_POS - 1);

  // Returns 1 when the discarded field is exactly one half LSB.
  function automatic logic is_tie(input logic [ACC_W-1:0] v);
    return (v[RND_POS-1:0] == TIE_PAT);
  endfunction

  // Add one half LSB, then clear the new LSB on an exact tie.
  function automatic logic [ACC_W-1:0] round_even(input logic [ACC_W-1:0] v);
    logic [ACC_W-1:0] t;
    t = v + HALF_LSB;
    if (is_tie(v))
      t[RND_POS] = 1'b0;
    return t;
  endfunction

  logic [ACC_W-1:0] rounded;

  always_comb begin
    rounded = round_even(sum_in);
    tie_hit = is_tie(sum_in);
    res_out = rnd_en ? rounded : sum_in;
  end

endmodule

// File: rtl/acc_ovf_detect.sv
module acc_ovf_detect #(
  parameter int GUARD_W = 9
) (
  input  logic [GUARD_W-1:0] top_bits,
  output logic               ovf
);

  // Overflow unless the window is a pure sign extension.
  function automatic logic window_ovf(input logic [GUARD_W-1:0] w);
    logic all_zero;
    logic all_one;
    all_zero = ~|w;
    all_one  = &w;
    return ~(all_zero | all_one);
  endfunction

  assign ovf = window_ovf(top_bits);

endmodule

// File: rtl/acc_sat_unit.sv
module acc_sat_unit #(
  parameter int HI_W   = 8,
  parameter int WORD_W = 16
) (
  input  logic                       ovf_flag,
  input  logic                       sign_msb,
  output logic                       sat_fire,
  output logic                       sat_neg,
  output logic [HI_W+2*WORD_W-1:0]   sat_val
);

  localparam int ACC_W  = HI_W + 2 * WORD_W;
  localparam int KEEP_W = 2 * WORD_W - 1;
  localparam int SIGN_W = ACC_W - KEEP_W;

  // Full scale of the 32-bit field, sign-extended through the guard bits.
  localparam logic [ACC_W-1:0] POS_FULL = {{SIGN_W{1'b0}}, {KEEP_W{1'b1}}};
  localparam logic [ACC_W-1:0] NEG_FULL = {{SIGN_W{1'b1}}, {KEEP_W{1'b0}}};

  function automatic logic [ACC_W-1:0] clamp_for(input logic neg);
    return neg ? NEG_FULL : POS_FULL;
  endfunction

  always_comb begin
    sat_fire = ovf_flag;
    sat_neg  = sign_msb;
    sat_val  = clamp_for(sign_msb);
  end

endmodule

// File: rtl/acc_load_unit.sv
module acc_load_unit #(
  parameter int HI_W   = 8,
  parameter int WORD_W = 16
) (
  input  logic [HI_W-1:0]   cur_hi,
  input  logic [WORD_W-1:0] cur_mid,
  input  logic [WORD_W-1:0] cur_lo,
  input  logic [WORD_W-1:0] bus_data,
  input  logic              ld_lo,
  input  logic              ld_mid,
  input  logic              ld_hi,
  output logic [HI_W-1:0]   nxt_hi,
  output logic [WORD_W-1:0] nxt_mid,
  output logic [WORD_W-1:0] nxt_lo,
  output logic              any_load
);

  logic [HI_W-1:0] sign_fill;

  // Each guard bit takes the sign of the loaded upper word.
  for (genvar g = 0; g < HI_W; g++) begin : g_fill
    assign sign_fill[g] = bus_data[WORD_W-1];
  end

  always_comb begin
    nxt_lo   = ld_lo  ? bus_data : cur_lo;
    nxt_mid  = ld_mid ? bus_data : cur_mid;
    // An explicit guard load beats the fill from an upper-word load.
    if (ld_hi)
      nxt_hi = bus_data[HI_W-1:0];
    else if (ld_mid)
      nxt_hi = sign_fill;
    else
      nxt_hi = cur_hi;
    any_load = ld_lo | ld_mid | ld_hi;
  end

endmodule

// File: rtl/acc_ext_reg.sv
module acc_ext_reg #(
  parameter int HI_W   = 8,
  parameter int WORD_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc_valid,
  input  logic [HI_W+2*WORD_W-1:0]     acc_sum,
  input  logic                         acc_round,
  input  logic                         acc_to_fb,
  input  logic                         sat_cmd,
  input  logic [WORD_W-1:0]            bus_data,
  input  logic                         ld_lo,
  input  logic                         ld_mid,
  input  logic                         ld_hi,
  output logic [HI_W-1:0]              mr_hi,
  output logic [WORD_W-1:0]            mr_mid,
  output logic [WORD_W-1:0]            mr_lo,
  output logic [WORD_W-1:0]            mr_hi_ext,
  output logic                         ovf_flag,
  output logic [WORD_W-1:0]            fb_word
);
  import acc_pkg::*;

  localparam int ACC_W   = HI_W + 2 * WORD_W;
  localparam int GUARD_W = HI_W + 1;
  localparam int MID_LSB = WORD_W;
  localparam int MID_MSB = 2 * WORD_W - 1;
  localparam int EXT_W   = WORD_W - HI_W;

  logic [ACC_W-1:0]  acc_q;
  logic              ovf_q;
  logic [WORD_W-1:0] fb_q;

  // Named internal events, observed by the checker.
  logic [ACC_W-1:0]  rnd_res;
  logic              rnd_mid;
  logic              ovf_next;
  logic              sat_fire;
  logic              sat_neg;
  logic [ACC_W-1:0]  sat_val;
  logic [HI_W-1:0]   ld_hi_nxt;
  logic [WORD_W-1:0] ld_mid_nxt;
  logic [WORD_W-1:0] ld_lo_nxt;
  logic              ld_any;
  acc_wr_e           wr_sel;
  logic [ACC_W-1:0]  acc_d;
  logic              ovf_d;
  logic [WORD_W-1:0] fb_d;

  acc_round_unit #(
    .ACC_W   (ACC_W),
    .RND_POS (WORD_W)
  ) u_round (
    .sum_in  (acc_sum),
    .rnd_en  (acc_round),
    .res_out (rnd_res),
    .tie_hit (rnd_mid)
  );

  acc_ovf_detect #(
    .GUARD_W (GUARD_W)
  ) u_ovf (
    .top_bits (rnd_res[ACC_W-1:ACC_W-GUARD_W]),
    .ovf      (ovf_next)
  );

  acc_sat_unit #(
    .HI_W   (HI_W),
    .WORD_W (WORD_W)
  ) u_sat (
    .ovf_flag (ovf_q),
    .sign_msb (acc_q[ACC_W-1]),
    .sat_fire (sat_fire),
    .sat_neg  (sat_neg),
    .sat_val  (sat_val)
  );

  acc_load_unit #(
    .HI_W   (HI_W),
    .WORD_W (WORD_W)
  ) u_load (
    .cur_hi   (acc_q[ACC_W-1:MID_MSB+1]),
    .cur_mid  (acc_q[MID_MSB:MID_LSB]),
    .cur_lo   (acc_q[WORD_W-1:0]),
    .bus_data (bus_data),
    .ld_lo    (ld_lo),
    .ld_mid   (ld_mid),
    .ld_hi    (ld_hi),
    .nxt_hi   (ld_hi_nxt),
    .nxt_mid  (ld_mid_nxt),
    .nxt_lo   (ld_lo_nxt),
    .any_load (ld_any)
  );

  always_comb begin
    wr_sel = pick_write(acc_valid, acc_to_fb, sat_cmd, ld_any);
    unique case (wr_sel)
      WR_ACC:  acc_d = rnd_res;
      WR_SAT:  acc_d = sat_fire ? sat_val : acc_q;
      WR_BUS:  acc_d = {ld_hi_nxt, ld_mid_nxt, ld_lo_nxt};
      default: acc_d = acc_q;
    endcase
    ovf_d = flag_update(acc_valid) ? ovf_next : ovf_q;
    fb_d  = (acc_valid && acc_to_fb) ? rnd_res[MID_MSB:MID_LSB] : fb_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      fb_q  <= '0;
    end else begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
      fb_q  <= fb_d;
    end
  end

  assign mr_hi     = acc_q[ACC_W-1:MID_MSB+1];
  assign mr_mid    = acc_q[MID_MSB:MID_LSB];
  assign mr_lo     = acc_q[WORD_W-1:0];
  assign mr_hi_ext = {{EXT_W{acc_q[ACC_W-1]}}, acc_q[ACC_W-1:MID_MSB+1]};
  assign ovf_flag  = ovf_q;
  assign fb_word   = fb_q;

endmodule

// File: rtl/acc_ext_reg_chk.sv
module acc_ext_reg_chk #(
  parameter int HI_W   = 8,
  parameter int WORD_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     acc_valid,
  input logic                     acc_round,
  input logic                     acc_to_fb,
  input logic                     sat_cmd,
  input logic [WORD_W-1:0]        bus_data,
  input logic                     ld_lo,
  input logic                     ld_mid,
  input logic                     ld_hi,
  input logic [HI_W-1:0]          mr_hi,
  input logic [WORD_W-1:0]        mr_mid,
  input logic [WORD_W-1:0]        mr_lo,
  input logic [WORD_W-1:0]        mr_hi_ext,
  input logic                     ovf_flag,
  input logic                     rnd_mid,
  input logic [HI_W+2*WORD_W-1:0] rnd_res
);

  localparam int ACC_W  = HI_W + 2 * WORD_W;
  localparam int EXT_N  = WORD_W - HI_W + 1;
  localparam logic [ACC_W-1:0] POS_FULL = {{(HI_W+1){1'b0}}, {(2*WORD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_FULL = {{(HI_W+1){1'b1}}, {(2*WORD_W-1){1'b0}}};

  logic quiet_ops;
  assign quiet_ops = !acc_valid && !sat_cmd;

  // R2
  lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_ops && ld_lo && !ld_mid && !ld_hi)
      |=> ($stable(mr_hi) && $stable(mr_mid) && mr_lo == $past(bus_data)));

  // R3
  mid_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_ops && ld_mid && !ld_hi)
      |=> (mr_hi == {HI_W{$past(bus_data[WORD_W-1])}}));

  // R4
  hi_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mr_hi_ext[WORD_W-1:HI_W-1]) == 0) ||
    ($countones(mr_hi_ext[WORD_W-1:HI_W-1]) == EXT_N));

  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(ovf_flag));

  // R6
  sat_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && sat_cmd && !ovf_flag)
      |=> ($stable(mr_hi) && $stable(mr_mid) && $stable(mr_lo)));

  // R7
  sat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && sat_cmd && ovf_flag && !mr_hi[HI_W-1])
      |=> ({mr_hi, mr_mid, mr_lo} == POS_FULL));

  // R7
  sat_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && sat_cmd && ovf_flag && mr_hi[HI_W-1])
      |=> ({mr_hi, mr_mid, mr_lo} == NEG_FULL));

  // R9
  tie_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_round && rnd_mid) |-> (rnd_res[WORD_W] == 1'b0));

  // R10
  fb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_to_fb)
      |=> ($stable(mr_hi) && $stable(mr_mid) && $stable(mr_lo)));

endmodule

bind acc_ext_reg acc_ext_reg_chk #(
  .HI_W   (HI_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_round (acc_round),
  .acc_to_fb (acc_to_fb),
  .sat_cmd   (sat_cmd),
  .bus_data  (bus_data),
  .ld_lo     (ld_lo),
  .ld_mid    (ld_mid),
  .ld_hi     (ld_hi),
  .mr_hi     (mr_hi),
  .mr_mid    (mr_mid),
  .mr_lo     (mr_lo),
  .mr_hi_ext (mr_hi_ext),
  .ovf_flag  (ovf_flag),
  .rnd_mid   (rnd_mid),
  .rnd_res   (rnd_res)
);

// File: tb/acc_ext_reg_bench.sv
`timescale 1ns/1ps
module acc_ext_reg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [39:0] acc_sum = '0;
  logic        acc_round = 1'b0;
  logic        acc_to_fb = 1'b0;
  logic        sat_cmd = 1'b0;
  logic [15:0] bus_data = '0;
  logic        ld_lo = 1'b0;
  logic        ld_mid = 1'b0;
  logic        ld_hi = 1'b0;
  logic [7:0]  mr_hi;
  logic [15:0] mr_mid;
  logic [15:0] mr_lo;
  logic [15:0] mr_hi_ext;
  logic        ovf_flag;
  logic [15:0] fb_word;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  acc_ext_reg #(.HI_W(8), .WORD_W(16)) u_acc_ext_reg (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sum(acc_sum),
    .acc_round(acc_round), .acc_to_fb(acc_to_fb), .sat_cmd(sat_cmd),
    .bus_data(bus_data), .ld_lo(ld_lo), .ld_mid(ld_mid), .ld_hi(ld_hi),
    .mr_hi(mr_hi), .mr_mid(mr_mid), .mr_lo(mr_lo), .mr_hi_ext(mr_hi_ext),
    .ovf_flag(ovf_flag), .fb_word(fb_word)
  );

  typedef struct {
    logic [39:0] acc;
    logic        ovf;
    logic [15:0] fb;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  // Model state
  logic [39:0] m_acc = '0;
  logic        m_ovf = 1'b0;
  logic [15:0] m_fb  = '0;

  function automatic logic [39:0] ref_round(input logic [39:0] s);
    logic [39:0] r;
    r = s + 40'h00_0000_8000;
    if (s[15:0] == 16'h8000) r = r & ~40'h00_0001_0000;
    return r;
  endfunction

  function automatic logic ref_ovf(input logic [39:0] v);
    return !((v[39:31] == 9'h000) || (v[39:31] == 9'h1FF));
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic av, input logic [39:0] s, input logic rnd,
                       input logic tofb, input logic sat, input logic [15:0] bus,
                       input logic l0, input logic l1, input logic l2,
                       input string tag);
    exp_t e;
    logic [39:0] r;
    @(negedge clk);
    acc_valid = av; acc_sum = s; acc_round = rnd; acc_to_fb = tofb;
    sat_cmd = sat; bus_data = bus; ld_lo = l0; ld_mid = l1; ld_hi = l2;
    if (av) begin
      r = rnd ? ref_round(s) : s;
      m_ovf = ref_ovf(r);
      if (tofb) m_fb = r[31:16];
      else      m_acc = r;
    end else if (sat) begin
      if (m_ovf) m_acc = m_acc[39] ? 40'hFF_8000_0000 : 40'h00_7FFF_FFFF;
    end else begin
      if (l0) m_acc[15:0] = bus;
      if (l1) begin
        m_acc[31:16] = bus;
        m_acc[39:32] = {8{bus[15]}};
      end
      if (l2) m_acc[39:32] = bus[7:0];
    end
    @(posedge clk);
    #1;
    e.acc = m_acc; e.ovf = m_ovf; e.fb = m_fb; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; acc_round = 1'b0; acc_to_fb = 1'b0; sat_cmd = 1'b0;
    ld_lo = 1'b0; ld_mid = 1'b0; ld_hi = 1'b0;
  endtask

  // Monitor: compares design outputs with the queued expectation.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(e.tag, "acc", {mr_hi, mr_mid, mr_lo}, e.acc);
        check(e.tag, "ovf", 40'(ovf_flag), 40'(e.ovf));
        check(e.tag, "fb", 40'(fb_word), 40'(e.fb));
        check("R4", "hi_ext", 40'(mr_hi_ext), 40'({{8{e.acc[39]}}, e.acc[39:32]}));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "acc in reset", {mr_hi, mr_mid, mr_lo}, 40'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "acc after reset", {mr_hi, mr_mid, mr_lo}, 40'h0);
    check("R1", "ovf after reset", 40'(ovf_flag), 40'h0);
    check("R1", "fb after reset", 40'(fb_word), 40'h0);

    drive(0, '0, 0, 0, 0, 16'h1234, 1, 0, 0, "R2 low load");
    drive(0, '0, 0, 0, 0, 16'h8001, 0, 1, 0, "R3 upper load negative fill");
    drive(0, '0, 0, 0, 0, 16'h7000, 0, 1, 0, "R3 upper load positive fill");
    drive(0, '0, 0, 0, 0, 16'h705A, 0, 1, 1, "R3 guard overrides fill");
    drive(0, '0, 0, 0, 0, 16'h0080, 0, 0, 1, "R4 guard load negative");
    drive(1, 40'h00_1234_5678, 0, 0, 0, '0, 0, 0, 0, "R5 accumulate no overflow");
    drive(1, 40'h01_0000_0000, 0, 0, 0, '0, 0, 0, 0, "R5 accumulate overflow");
    drive(0, '0, 0, 0, 0, 16'hBEEF, 1, 0, 0, "R2 load keeps ovf");
    drive(0, '0, 0, 0, 1, '0, 0, 0, 0, "R7 saturate positive");
    drive(1, 40'h80_0000_0000, 0, 0, 0, '0, 0, 0, 0, "R5 negative overflow");
    drive(0, '0, 0, 0, 1, '0, 0, 0, 0, "R7 saturate negative");
    drive(1, 40'hFF_8000_0000, 0, 0, 0, '0, 0, 0, 0, "R5 top nine all ones");
    drive(0, '0, 0, 0, 1, '0, 0, 0, 0, "R6 saturate without overflow");
    drive(1, 40'h00_0025_C123, 1, 0, 0, '0, 0, 0, 0, "R8 round up");
    drive(1, 40'h00_0025_4123, 1, 0, 0, '0, 0, 0, 0, "R8 round down");
    drive(1, 40'h00_0066_8000, 1, 0, 0, '0, 0, 0, 0, "R9 tie odd forced even");
    drive(1, 40'h00_0067_8000, 1, 0, 0, '0, 0, 0, 0, "R9 tie rounds to even");
    drive(1, 40'h00_FFFF_8001, 1, 0, 0, '0, 0, 0, 0, "R8 carry into guard");
    drive(1, 40'hFF_FFFF_8000, 1, 0, 0, '0, 0, 0, 0, "R9 negative tie wraps");
    drive(1, 40'h12_3456_9ABC, 1, 1, 0, '0, 0, 0, 0, "R10 rounded to feedback");
    drive(1, 40'h00_ABCD_0000, 0, 1, 0, '0, 0, 0, 0, "R10 plain to feedback");
    drive(1, 40'h00_0000_0005, 0, 0, 1, 16'hFFFF, 1, 1, 1, "R11 accumulate wins");
    drive(0, '0, 0, 0, 1, 16'h4321, 1, 0, 0, "R11 saturate beats load");
    drive(1, 40'hFF_FFFF_FFFE, 0, 0, 0, '0, 0, 0, 0, "R5 small negative");
    idle();
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule